// File: doc/BRIEF.md
# Row-Parallel In-Array Logic Engine

This block is a behavioural model of a bit array that can compute inside itself. In memory mode it acts as a plain row-addressed store: one row is written or read per cycle through a word-wide port. In logic mode a single command names up to three source columns, one destination column and a gate type. Every row then evaluates that gate on its own cells at the same time, and the result lands in the destination column of the same row. No data leaves the array.

The gate is modelled as a conditional switch. In a first cycle the destination cell of every row is forced to a preset value fixed by the gate type. In a second cycle it flips away from that preset only when the number of source cells holding 1 meets the gate's threshold. The cycle after that, a one-cycle done strobe is raised. A command whose destination column coincides with one of the source columns the gate actually uses is refused. It raises a one-cycle error strobe and leaves the array untouched.

Top module: `rowlogic_array`

## Requirements
- R1: After reset every cell reads 0, and busy, done, err and mem_rdata are 0.
- R2: While mem_ready is 1, mem_en with mem_we=1 stores mem_wdata in row mem_row. mem_en with mem_we=0 returns that row on mem_rdata one cycle later, and mem_rdata then holds until the next accepted read.
- R3: Gate codes on cmd_gate are 0 NOT(a), 1 BUF(a), 2 AND(a,b), 3 NAND(a,b), 4 OR(a,b), 5 NOR(a,b), 6 majority(a,b,c) and 7 inverted majority(a,b,c). The destination cell ends holding that function of the source cells of its own row.
- R4: The destination column is first preset in every row: to 1 for NAND, NOR and inverted majority, and to 0 for the other gates. It leaves the preset only when the count of 1s among the used sources reaches the gate's threshold (NOT: count below 1; BUF, OR, NOR: at least 1; AND, NAND, majority, inverted majority: at least 2). Otherwise it keeps the preset.
- R5: One command updates the destination column in all rows at once and changes no other column.
- R6: An accepted command keeps busy high for exactly two cycles after the accepting edge. done is high for exactly the one cycle after that.
- R7: mem_ready is 1 only when the engine is idle and cmd_valid is 0. Memory requests made while mem_ready is 0 neither write the array nor change mem_rdata.
- R8: A command whose destination equals a source column used by its gate is refused. err pulses for one cycle, done is not raised and the array is unchanged. Equality with an unused source field does not cause a refusal.
- R9: cmd_valid while busy is ignored.
- R10: Any column may serve as a source or a destination. A column written by one command can feed a later one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Logic command request |
| cmd_gate | input | 3 | Gate code |
| cmd_src_a | input | CW | First source column |
| cmd_src_b | input | CW | Second source column |
| cmd_src_c | input | CW | Third source column |
| cmd_dst | input | CW | Destination column |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command finished strobe |
| err | output | 1 | Command refused strobe |
| mem_ready | output | 1 | Memory port can accept a request |
| mem_en | input | 1 | Memory request |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_row | input | RW | Row index |
| mem_wdata | input | COLS | Write word |
| mem_rdata | output | COLS | Read word |

## Verification
The assertions assume that every column and row index on the inputs is in range, which holds for power-of-two array sizes. They also assume that inputs are stable around the clock edge. The stimulus changes all inputs on the falling edge. It uses only power-of-two sizes, and it deliberately drives memory requests and second commands while the engine is busy, so that the refusal and stall rules are exercised rather than avoided. The source rows carry every 3-bit pattern in the columns used as gate inputs, so each gate meets every input combination in one command.

// File: rtl/rla_pkg.sv
// Shared types and gate properties for the row-parallel logic engine.
// Assumes a gate code is 3 bits wide; every code is a legal gate.
package rla_pkg;

    typedef enum logic [2:0] {
        G_NOT  = 3'd0,
        G_BUF  = 3'd1,
        G_AND  = 3'd2,
        G_NAND = 3'd3,
        G_OR   = 3'd4,
        G_NOR  = 3'd5,
        G_MAJ  = 3'd6,
        G_MINV = 3'd7
    } gate_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PRE  = 2'd1,
        PH_EVAL = 2'd2
    } phase_t;

    // Number of source columns a gate reads.
    function automatic logic [1:0] gate_arity(gate_t g);
        case (g)
            G_NOT, G_BUF:  return 2'd1;
            G_MAJ, G_MINV: return 2'd3;
            default:       return 2'd2;
        endcase
    endfunction

    // Value the destination cell holds before evaluation.
    function automatic logic gate_preset(gate_t g);
        return (g == G_NAND) || (g == G_NOR) || (g == G_MINV);
    endfunction

    // Count of ones that decides the flip.
    function automatic logic [1:0] gate_thresh(gate_t g);
        case (g)
            G_AND, G_NAND, G_MAJ, G_MINV: return 2'd2;
            default:                      return 2'd1;
        endcase
    endfunction

    // 1 when the flip happens below the threshold instead of at or above it.
    function automatic logic gate_below(gate_t g);
        return g == G_NOT;
    endfunction

endpackage

// File: rtl/rla_cmd_check.sv
// Refusal decode: flags a command whose destination column equals a
// source column that its gate actually reads. Purely combinational.
module rla_cmd_check
    import rla_pkg::*;
#(
    parameter int CW = 4
) (
    input  gate_t         gate,
    input  logic [CW-1:0] src_a,
    input  logic [CW-1:0] src_b,
    input  logic [CW-1:0] src_c,
    input  logic [CW-1:0] dst,
    output logic          conflict
);

    logic [1:0] arity;

    // Compare the destination only against sources in use.
    always_comb begin
        arity    = gate_arity(gate);
        conflict = (dst == src_a)
                 || ((arity >= 2'd2) && (dst == src_b))
                 || ((arity == 2'd3) && (dst == src_c));
    end

endmodule

// File: rtl/rla_row_eval.sv
// Evaluates the latched gate on one row: counts the ones among the used
// sources and flips the preset when the threshold rule is met.
// Assumes the source indices are below COLS.
module rla_row_eval
    import rla_pkg::*;
#(
    parameter int COLS = 16,
    parameter int CW   = 4
) (
    input  logic [COLS-1:0] word,
    input  gate_t           gate,
    input  logic [CW-1:0]   src_a,
    input  logic [CW-1:0]   src_b,
    input  logic [CW-1:0]   src_c,
    output logic            result
);

    logic [1:0] arity;
    logic [1:0] ones;
    logic       flip;

    // Threshold switching rule on the count of ones.
    always_comb begin
        arity = gate_arity(gate);
        ones  = {1'b0, word[src_a]};
        if (arity >= 2'd2) ones = ones + {1'b0, word[src_b]};
        if (arity == 2'd3) ones = ones + {1'b0, word[src_c]};
        if (gate_below(gate)) flip = ones < gate_thresh(gate);
        else                  flip = ones >= gate_thresh(gate);
        result = gate_preset(gate) ^ flip;
    end

endmodule

// File: rtl/rla_seq.sv
// Command sequencer: idle -> preset -> evaluate -> idle, with done and
// err strobes. Assumes conflict is valid in the same cycle as cmd_valid.
module rla_seq
    import rla_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cmd_valid,
    input  logic   conflict,
    output phase_t phase,
    output logic   accept,
    output logic   done,
    output logic   err
);

    // Accept a clean command only while idle.
    always_comb accept = (phase == PH_IDLE) && cmd_valid && !conflict;

    // Phase register and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            done  <= 1'b0;
            err   <= 1'b0;
        end else begin
            done <= (phase == PH_EVAL);
            err  <= (phase == PH_IDLE) && cmd_valid && conflict;
            case (phase)
                PH_IDLE: if (accept) phase <= PH_PRE;
                PH_PRE:  phase <= PH_EVAL;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_DONE_AFTER_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(phase == PH_EVAL)); // R6
    AST_PRE_THEN_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PRE) |=> (phase == PH_EVAL)); // R6
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err)); // R8
    AST_ERR_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (phase == PH_IDLE)); // R8

endmodule

// File: rtl/rowlogic_array.sv
// Bit array with row-wide memory access and a row-parallel logic mode.
// A logic command presets one column in every row, then conditionally
// flips it from sources in the same row. The memory port is stalled
// while a command runs. Assumes ROWS and COLS are powers of two.
module rowlogic_array
    import rla_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 16,
    localparam int CW  = $clog2(COLS),
    localparam int RW  = $clog2(ROWS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_gate,
    input  logic [CW-1:0]   cmd_src_a,
    input  logic [CW-1:0]   cmd_src_b,
    input  logic [CW-1:0]   cmd_src_c,
    input  logic [CW-1:0]   cmd_dst,
    output logic            busy,
    output logic            done,
    output logic            err,
    output logic            mem_ready,
    input  logic            mem_en,
    input  logic            mem_we,
    input  logic [RW-1:0]   mem_row,
    input  logic [COLS-1:0] mem_wdata,
    output logic [COLS-1:0] mem_rdata
);

    logic [ROWS-1:0][COLS-1:0] cells;
    logic [ROWS-1:0]           row_res;
    phase_t                    phase;
    logic                      accept;
    logic                      conflict;
    gate_t                     q_gate;
    logic [CW-1:0]             q_a, q_b, q_c, q_dst;
    logic                      q_preset;

    rla_cmd_check #(.CW(CW)) u_check (
        .gate     (gate_t'(cmd_gate)),
        .src_a    (cmd_src_a),
        .src_b    (cmd_src_b),
        .src_c    (cmd_src_c),
        .dst      (cmd_dst),
        .conflict (conflict)
    );

    rla_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .conflict  (conflict),
        .phase     (phase),
        .accept    (accept),
        .done      (done),
        .err       (err)
    );

    // Port-level status.
    always_comb begin
        busy      = (phase != PH_IDLE);
        mem_ready = (phase == PH_IDLE) && !cmd_valid;
        q_preset  = gate_preset(q_gate);
    end

    // Hold the accepted command for the two execution cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_gate <= G_NOT;
            q_a    <= '0;
            q_b    <= '0;
            q_c    <= '0;
            q_dst  <= '0;
        end else if (accept) begin
            q_gate <= gate_t'(cmd_gate);
            q_a    <= cmd_src_a;
            q_b    <= cmd_src_b;
            q_c    <= cmd_src_c;
            q_dst  <= cmd_dst;
        end
    end

    // One evaluator per row, all working on the same command.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        rla_row_eval #(.COLS(COLS), .CW(CW)) u_eval (
            .word   (cells[r]),
            .gate   (q_gate),
            .src_a  (q_a),
            .src_b  (q_b),
            .src_c  (q_c),
            .result (row_res[r])
        );

        AST_PRESET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (phase == PH_EVAL) |-> (cells[r][q_dst] == q_preset)); // R4
    end

    // Array update: preset, evaluate, or a memory access when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cells     <= '0;
            mem_rdata <= '0;
        end else begin
            case (phase)
                PH_PRE: begin
                    for (int r = 0; r < ROWS; r++) cells[r][q_dst] <= q_preset;
                end
                PH_EVAL: begin
                    for (int r = 0; r < ROWS; r++) cells[r][q_dst] <= row_res[r];
                end
                default: begin
                    if (mem_ready && mem_en) begin
                        if (mem_we) cells[mem_row] <= mem_wdata;
                        else        mem_rdata      <= cells[mem_row];
                    end
                end
            endcase
        end
    end

    AST_ERR_KEEPS_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (cells == $past(cells))); // R8
    AST_STALL_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mem_rdata)); // R7

endmodule

// File: tb/rowlogic_array_bench.sv
`timescale 1ns/1ps
module rowlogic_array_bench;

    localparam int ROWS = 8;
    localparam int COLS = 16;
    localparam int CW   = 4;
    localparam int RW   = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic [2:0]      cmd_gate = '0;
    logic [CW-1:0]   cmd_src_a = '0, cmd_src_b = '0, cmd_src_c = '0, cmd_dst = '0;
    logic            busy, done, err, mem_ready;
    logic            mem_en = 1'b0, mem_we = 1'b0;
    logic [RW-1:0]   mem_row = '0;
    logic [COLS-1:0] mem_wdata = '0;
    logic [COLS-1:0] mem_rdata;

    int n_checks = 0;
    int n_fail   = 0;

    rowlogic_array #(.ROWS(ROWS), .COLS(COLS)) u_rowlogic_array (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_gate(cmd_gate),
        .cmd_src_a(cmd_src_a), .cmd_src_b(cmd_src_b), .cmd_src_c(cmd_src_c),
        .cmd_dst(cmd_dst), .busy(busy), .done(done), .err(err),
        .mem_ready(mem_ready), .mem_en(mem_en), .mem_we(mem_we),
        .mem_row(mem_row), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference model.
    bit [COLS-1:0] m_cells [ROWS];
    int            m_phase;
    bit            m_done, m_err;
    bit [COLS-1:0] m_rdata;
    int            m_g, m_a, m_b, m_c, m_d;

    function automatic bit gate_fn(int g, bit a, bit b, bit c);
        bit maj;
        maj = (a & b) | (a & c) | (b & c);
        case (g)
            0: return ~a;
            1: return a;
            2: return a & b;
            3: return ~(a & b);
            4: return a | b;
            5: return ~(a | b);
            6: return maj;
            default: return ~maj;
        endcase
    endfunction

    function automatic bit preset_of(int g);
        return (g == 3) || (g == 5) || (g == 7);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_cells[r]) m_cells[r] = '0;
            m_phase = 0; m_done = 0; m_err = 0; m_rdata = '0;
        end else begin
            m_done = 0;
            m_err  = 0;
            case (m_phase)
                0: begin
                    if (cmd_valid) begin
                        int g;
                        bit bad;
                        g = int'(cmd_gate);
                        bad = (cmd_dst == cmd_src_a);
                        if (g >= 2 && cmd_dst == cmd_src_b) bad = 1;
                        if (g >= 6 && cmd_dst == cmd_src_c) bad = 1;
                        if (bad) m_err = 1;
                        else begin
                            m_g = g; m_a = int'(cmd_src_a); m_b = int'(cmd_src_b);
                            m_c = int'(cmd_src_c); m_d = int'(cmd_dst);
                            m_phase = 1;
                        end
                    end else if (mem_en) begin
                        if (mem_we) m_cells[mem_row] = mem_wdata;
                        else        m_rdata = m_cells[mem_row];
                    end
                end
                1: begin
                    foreach (m_cells[r]) m_cells[r][m_d] = preset_of(m_g);
                    m_phase = 2;
                end
                default: begin
                    foreach (m_cells[r])
                        m_cells[r][m_d] = gate_fn(m_g, m_cells[r][m_a],
                                                  m_cells[r][m_b], m_cells[r][m_c]);
                    m_done  = 1;
                    m_phase = 0;
                end
            endcase
        end
        #1;
        if (rst_n) begin
            chk(done == m_done, "R6", "done", 32'(done), 32'(m_done));
            chk(busy == (m_phase != 0), "R6", "busy", 32'(busy), 32'(m_phase != 0));
            chk(err == m_err, "R8", "err", 32'(err), 32'(m_err));
            chk(mem_rdata == m_rdata, "R2", "mem_rdata", 32'(mem_rdata), 32'(m_rdata));
            chk(mem_ready == (m_phase == 0 && !cmd_valid), "R7", "mem_ready",
                32'(mem_ready), 32'(m_phase == 0 && !cmd_valid));
        end
    end

    task automatic wr(input int row, input logic [COLS-1:0] d);
        @(negedge clk);
        mem_en = 1; mem_we = 1; mem_row = RW'(row); mem_wdata = d;
        @(negedge clk);
        mem_en = 0; mem_we = 0;
    endtask

    task automatic rd_check(input int row, input string tag);
        @(negedge clk);
        mem_en = 1; mem_we = 0; mem_row = RW'(row);
        @(negedge clk);
        mem_en = 0;
        chk(mem_rdata == m_cells[row], tag, $sformatf("row %0d", row),
            32'(mem_rdata), 32'(m_cells[row]));
    endtask

    task automatic rd_all(input string tag);
        for (int r = 0; r < ROWS; r++) rd_check(r, tag);
    endtask

    // Issue a command and check its strobe timing at the ports.
    task automatic run_cmd(input int g, input int a, input int b, input int c,
                           input int d, input bit expect_ok);
        @(negedge clk);
        cmd_valid = 1; cmd_gate = 3'(g);
        cmd_src_a = CW'(a); cmd_src_b = CW'(b); cmd_src_c = CW'(c); cmd_dst = CW'(d);
        @(negedge clk);
        cmd_valid = 0;
        if (expect_ok) begin
            chk(busy && !done && !err, "R6", "phase1 busy", {busy, done, err}, 3'b100);
            @(negedge clk);
            chk(busy && !done, "R6", "phase2 busy", {busy, done}, 2'b10);
            @(negedge clk);
            chk(!busy && done, "R6", "done strobe", {busy, done}, 2'b01);
            @(negedge clk);
            chk(!done, "R6", "done one cycle", 32'(done), 0);
        end else begin
            chk(err && !busy, "R8", "refused", {err, busy}, 2'b10);
            @(negedge clk);
            chk(!err && !done, "R8", "err one cycle", {err, done}, 2'b00);
        end
    endtask

    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below 100000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !err, "R1", "strobes after reset", {busy, done, err}, 0);
        chk(mem_rdata == '0, "R1", "rdata after reset", 32'(mem_rdata), 0);
        rd_all("R1");
        // R2: memory writes, sources hold every 3-bit pattern in cols 0..2
        for (int r = 0; r < ROWS; r++)
            wr(r, {13'(r * 13'd4679 + 13'd91), 3'(r)});
        rd_all("R2");
        // R3 R4 R5: every gate into its own column, all rows at once
        for (int g = 0; g < 8; g++) begin
            run_cmd(g, 0, 1, 2, 3 + g, 1);
            rd_all(g % 2 == 1 ? "R4" : "R3");
        end
        rd_all("R5");
        // R10: computed columns reused as sources, and col 0 as destination
        run_cmd(2, 4, 7, 0, 0, 1);
        run_cmd(6, 0, 15, 9, 12, 1);
        rd_all("R10");
        // R8: refused command, and a harmless clash on an unused field
        run_cmd(4, 5, 7, 0, 7, 0);
        rd_all("R8");
        run_cmd(7, 1, 2, 13, 13, 0);
        rd_all("R8");
        run_cmd(0, 12, 15, 15, 15, 1);
        rd_all("R8");
        // R7 R9: memory request and second command while busy are ignored
        @(negedge clk);
        cmd_valid = 1; cmd_gate = 3'd1; cmd_src_a = 4'd1; cmd_dst = 4'd14;
        @(negedge clk);
        cmd_valid = 1; cmd_gate = 3'd0; cmd_src_a = 4'd2; cmd_dst = 4'd11;
        mem_en = 1; mem_we = 1; mem_row = 3'd5; mem_wdata = 16'hFFFF;
        @(negedge clk);
        mem_en = 1; mem_we = 0; mem_row = 3'd2; cmd_valid = 0;
        chk(!mem_ready, "R7", "stalled port", 32'(mem_ready), 0);
        @(negedge clk);
        mem_en = 0;
        repeat (2) @(negedge clk);
        rd_all("R9");
        rd_check(5, "R7");
        // R7: request alongside cmd_valid in idle is dropped
        @(negedge clk);
        cmd_valid = 1; cmd_gate = 3'd4; cmd_src_a = 4'd3; cmd_src_b = 4'd3; cmd_dst = 4'd3;
        mem_en = 1; mem_we = 1; mem_row = 3'd6; mem_wdata = 16'h1234;
        @(negedge clk);
        cmd_valid = 0; mem_en = 0;
        rd_check(6, "R7");
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule